// File: doc/BRIEF.md
# Peripheral Region Remap Matcher

This block keeps a programmable window register that marks one naturally aligned region of the physical address space as belonging to a dedicated peripheral port. Every outgoing access address is compared against the window. On a hit the block replaces the access's memory attributes with the non-shared device type and raises a routing flag toward the peripheral port. Attributes from the translation tables or from any lower-priority remap stage are overridden. The comparison is the same whether address translation is on or off. With translation off, the caller presents the physical address, which equals the virtual one.

The register exists in two copies, one for the secure world and one for the non-secure world. A privileged register-access port reads and writes them, and the security state of the request selects the copy. A user-mode request, or a secure write while the secure lockout input is high, raises an undefined-instruction fault and changes nothing. The copy used for matching is chosen by the security bit of the access under test.

Top module: `perip_remap_matcher`

## Requirements
- R1: After reset both copies read as 0x00000000, and no address hits in either world.
- R2: A privileged write stores bits [31:12] as the base and bits [4:0] as the size code. A privileged read returns them in the same positions, with bits [11:5] always reading as zero.
- R3: For a size code c in 3..22 the window is 2^(c+9) bytes (code 3 = 4KB up to code 22 = 2GB). An address hits when it lies from the aligned base up to the aligned base plus the size, minus one.
- R4: Base bits from bit 12 up to bit c+8 are stored as written but ignored in the comparison, so the window is the base rounded down to the region size.
- R5: Size codes 0, 1, 2 and 23..31 mean no region: nothing hits, and the code still reads back as written.
- R6: On a hit, out_attr is forced to 4'b0001 (non-shared device) and to_periph is 1. On a miss, out_attr equals in_attr and to_periph is 0.
- R7: A secure privileged request accesses the secure copy, and a non-secure privileged request accesses the non-secure copy. Matching uses the secure copy when acc_secure is 1 and the non-secure copy otherwise.
- R8: A request with cfg_priv=0 raises undef_fault in the same cycle, writes nothing and returns cfg_rdata = 0.
- R9: A secure privileged write while sec_wr_lock is 1 raises undef_fault and leaves the secure copy unchanged. Non-secure writes and secure reads are unaffected by the lockout.
- R10: A register write changes matching from the cycle after the clock edge that accepts it. In the cycle of the write, the old value still decides the match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Register-access request valid |
| cfg_wr | input | 1 | 1 = write, 0 = read |
| cfg_priv | input | 1 | Requester is privileged |
| cfg_secure | input | 1 | Requester is in the secure world |
| sec_wr_lock | input | 1 | Blocks secure writes when high |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data (zero unless a permitted read) |
| undef_fault | output | 1 | Undefined-instruction fault for the current request |
| acc_addr | input | 32 | Address of the access being checked |
| acc_secure | input | 1 | Security state of the checked access |
| in_attr | input | 4 | Attributes from lower-priority sources |
| out_attr | output | 4 | Resulting attributes |
| to_periph | output | 1 | Access goes to the peripheral port |

## Verification
The bench probes the first and last byte of windows at the smallest and largest sizes, and the bytes just outside them. An off-by-one in the size decode would shift one edge and turn one of these probes into a false hit or a miss. A base with low bits set inside a 64KB window checks that those bits are masked; a design that compared them would miss at the true window start. Reserved codes on both sides of the legal range check the no-region rule, and writes to each copy check the banking. A design that shared the copies, or selected the match copy by the requester's world, would hit in the wrong world. Lockout and user-mode writes are followed by read-back and a probe. A probe taken during the write cycle exposes a design that matched on the incoming data too early.

// File: rtl/perip_remap_pkg.sv
package perip_remap_pkg;
   localparam int ATTR_W = 4;
   localparam logic [ATTR_W-1:0] ATTR_DEV_NONSHARED = 4'b0001;
endpackage

// File: rtl/remap_bank.sv
module remap_bank #(
   parameter int ADDR_W   = 32,
   parameter int BASE_LSB = 12,
   parameter int SIZE_W   = 5
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we,
   input  logic [ADDR_W-1:BASE_LSB] d_base,
   input  logic [SIZE_W-1:0]        d_size,
   output logic [ADDR_W-1:BASE_LSB] q_base,
   output logic [SIZE_W-1:0]        q_size
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_base <= '0;
         q_size <= '0;
      end else if (we) begin
         q_base <= d_base;
         q_size <= d_size;
      end
   end

   // R10: accepted write visible next cycle
   p_update_r10: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (q_base == $past(d_base) && q_size == $past(d_size)));
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> ($stable(q_base) && $stable(q_size)));
endmodule

// File: rtl/remap_size_decode.sv
module remap_size_decode #(
   parameter int ADDR_W   = 32,
   parameter int BASE_LSB = 12,
   parameter int SIZE_W   = 5,
   parameter int MIN_CODE = 3,
   parameter int MAX_CODE = 22
) (
   input  logic [SIZE_W-1:0]        code,
   output logic                     valid,
   output logic [ADDR_W-1:BASE_LSB] cmp_mask
);
   localparam int BIAS = BASE_LSB - MIN_CODE;

   assign valid = (int'(code) >= MIN_CODE) && (int'(code) <= MAX_CODE);

   for (genvar i = BASE_LSB; i < ADDR_W; i++) begin : g_mask
      assign cmp_mask[i] = valid && ((int'(code) + BIAS) <= i);
   end
endmodule

// File: rtl/remap_window_cmp.sv
module remap_window_cmp #(
   parameter int ADDR_W   = 32,
   parameter int BASE_LSB = 12
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [ADDR_W-1:0]        addr,
   input  logic [ADDR_W-1:BASE_LSB] base,
   input  logic [ADDR_W-1:BASE_LSB] cmp_mask,
   input  logic                     region_valid,
   output logic                     hit
);
   logic [ADDR_W-1:BASE_LSB] diff;
   assign diff = (addr[ADDR_W-1:BASE_LSB] ^ base) & cmp_mask;
   assign hit  = region_valid && (diff == '0);

   // R5: a region with no legal size never matches
   p_nohit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !region_valid |-> !hit);
endmodule

// File: rtl/perip_remap_matcher.sv
module perip_remap_matcher
   import perip_remap_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int BASE_LSB = 12,
   parameter int SIZE_W   = 5,
   parameter int MIN_CODE = 3,
   parameter int MAX_CODE = 22
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_en,
   input  logic              cfg_wr,
   input  logic              cfg_priv,
   input  logic              cfg_secure,
   input  logic              sec_wr_lock,
   input  logic [ADDR_W-1:0] cfg_wdata,
   output logic [ADDR_W-1:0] cfg_rdata,
   output logic              undef_fault,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              acc_secure,
   input  logic [ATTR_W-1:0] in_attr,
   output logic [ATTR_W-1:0] out_attr,
   output logic              to_periph
);
   localparam int NBANK = 2;
   localparam int SBZ_W = BASE_LSB - SIZE_W;

   if (MAX_CODE + BASE_LSB - MIN_CODE > ADDR_W) begin : g_chk_range
      $error("largest region exceeds address width");
   end
   if (SBZ_W < 1) begin : g_chk_fields
      $error("size field overlaps base field");
   end
   if ((1 << SIZE_W) <= MAX_CODE) begin : g_chk_code
      $error("size field too narrow for MAX_CODE");
   end

   logic rd_ok, wr_ok;
   logic [NBANK-1:0] bank_we;
   logic [ADDR_W-1:BASE_LSB] q_base [NBANK];
   logic [SIZE_W-1:0]        q_size [NBANK];
   logic [SBZ_W-1:0]         unused_sbz;

   assign unused_sbz = cfg_wdata[BASE_LSB-1:SIZE_W];

   assign undef_fault = cfg_en && (!cfg_priv || (cfg_wr && cfg_secure && sec_wr_lock));
   assign wr_ok = cfg_en && cfg_wr && !undef_fault;
   assign rd_ok = cfg_en && !cfg_wr && !undef_fault;

   // bank index 1 = secure, 0 = non-secure
   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      assign bank_we[b] = wr_ok && (cfg_secure == (b == 1));
      remap_bank #(.ADDR_W(ADDR_W), .BASE_LSB(BASE_LSB), .SIZE_W(SIZE_W)) u_bank (
         .clk    (clk),
         .rst_n  (rst_n),
         .we     (bank_we[b]),
         .d_base (cfg_wdata[ADDR_W-1:BASE_LSB]),
         .d_size (cfg_wdata[SIZE_W-1:0]),
         .q_base (q_base[b]),
         .q_size (q_size[b])
      );
   end

   logic [ADDR_W-1:BASE_LSB] rd_base, m_base, m_mask;
   logic [SIZE_W-1:0]        rd_size, m_size;
   logic                     m_valid, hit;

   assign rd_base = cfg_secure ? q_base[1] : q_base[0];
   assign rd_size = cfg_secure ? q_size[1] : q_size[0];
   assign cfg_rdata = rd_ok ? {rd_base, {SBZ_W{1'b0}}, rd_size} : '0;

   assign m_base = acc_secure ? q_base[1] : q_base[0];
   assign m_size = acc_secure ? q_size[1] : q_size[0];

   remap_size_decode #(.ADDR_W(ADDR_W), .BASE_LSB(BASE_LSB), .SIZE_W(SIZE_W),
                       .MIN_CODE(MIN_CODE), .MAX_CODE(MAX_CODE)) u_dec (
      .code     (m_size),
      .valid    (m_valid),
      .cmp_mask (m_mask)
   );

   remap_window_cmp #(.ADDR_W(ADDR_W), .BASE_LSB(BASE_LSB)) u_cmp (
      .clk          (clk),
      .rst_n        (rst_n),
      .addr         (acc_addr),
      .base         (m_base),
      .cmp_mask     (m_mask),
      .region_valid (m_valid),
      .hit          (hit)
   );

   assign out_attr  = hit ? ATTR_DEV_NONSHARED : in_attr;
   assign to_periph = hit;

   p_force_r6: assert property (@(posedge clk) disable iff (!rst_n)
      to_periph |-> (out_attr == ATTR_DEV_NONSHARED));
   p_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !to_periph |-> (out_attr == in_attr));
   p_sbz_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_rdata[BASE_LSB-1:SIZE_W] == '0);
   p_user_nowrite_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_en && !cfg_priv) |=> ($stable(q_base[0]) && $stable(q_base[1])
                                 && $stable(q_size[0]) && $stable(q_size[1])));
   p_lock_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_en && cfg_wr && cfg_secure && sec_wr_lock) |=> ($stable(q_base[1]) && $stable(q_size[1])));
endmodule

// File: tb/perip_remap_matcher_bench.sv
module perip_remap_matcher_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_en = 0, cfg_wr = 0, cfg_priv = 0, cfg_secure = 0, sec_wr_lock = 0;
   logic [31:0] cfg_wdata = 0, cfg_rdata, acc_addr = 0;
   logic acc_secure = 0, undef_fault, to_periph;
   logic [3:0] in_attr = 4'hA, out_attr;
   int n_chk = 0, n_bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   perip_remap_matcher u_perip_remap_matcher (
      .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_wr(cfg_wr), .cfg_priv(cfg_priv),
      .cfg_secure(cfg_secure), .sec_wr_lock(sec_wr_lock), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .undef_fault(undef_fault), .acc_addr(acc_addr),
      .acc_secure(acc_secure), .in_attr(in_attr), .out_attr(out_attr), .to_periph(to_periph));

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(bit sec, bit priv, logic [31:0] d, bit exp_fault, string req);
      @(negedge clk);
      cfg_en = 1; cfg_wr = 1; cfg_secure = sec; cfg_priv = priv; cfg_wdata = d;
      #1 check(req, {31'd0, undef_fault}, {31'd0, exp_fault});
      @(negedge clk);
      cfg_en = 0; cfg_wr = 0;
   endtask

   task automatic rd(bit sec, logic [31:0] exp, string req);
      @(negedge clk);
      cfg_en = 1; cfg_wr = 0; cfg_secure = sec; cfg_priv = 1;
      #1 check(req, cfg_rdata, exp);
      check(req, {31'd0, undef_fault}, 32'd0);
      cfg_en = 0;
   endtask

   task automatic probe(logic [31:0] a, bit sec, logic [3:0] attr, bit exp_hit, string req);
      @(negedge clk);
      acc_addr = a; acc_secure = sec; in_attr = attr;
      #1 check(req, {31'd0, to_periph}, {31'd0, exp_hit});
      check(req, {28'd0, out_attr}, {28'd0, exp_hit ? 4'b0001 : attr});
   endtask

   task automatic t_reset;
      rd(0, 32'h0, "R1 ns reset");
      rd(1, 32'h0, "R1 s reset");
      probe(32'h0, 0, 4'h6, 0, "R1 ns nohit");
      probe(32'h0, 1, 4'h6, 0, "R1 s nohit");
   endtask

   task automatic t_basic;
      wr(0, 1, 32'h4000_0FE7, 0, "R2 ns write");
      rd(0, 32'h4000_0007, "R2 readback sbz zero");
      probe(32'h4000_0000, 0, 4'hA, 1, "R3 R6 first byte");
      probe(32'h4000_FFFF, 0, 4'hA, 1, "R3 last byte");
      probe(32'h4001_0000, 0, 4'hA, 0, "R3 R6 above");
      probe(32'h3FFF_FFFF, 0, 4'h3, 0, "R3 below");
      probe(32'h4000_0000, 1, 4'hA, 0, "R7 secure copy empty");
      rd(1, 32'h0, "R7 secure untouched");
   endtask

   task automatic t_mask;
      wr(1, 1, 32'h8000_5007, 0, "R7 s write");
      rd(1, 32'h8000_5007, "R4 stored as written");
      probe(32'h8000_0000, 1, 4'hC, 1, "R4 aligned start");
      probe(32'h8000_F000, 1, 4'hC, 1, "R4 window end");
      probe(32'h8001_0000, 1, 4'hC, 0, "R4 above");
      probe(32'h8000_0000, 0, 4'hC, 0, "R7 ns copy does not match");
   endtask

   task automatic t_extremes;
      wr(0, 1, 32'h1234_5003, 0, "R3 4KB write");
      probe(32'h1234_5FFF, 0, 4'h5, 1, "R3 4KB last");
      probe(32'h1234_6000, 0, 4'h5, 0, "R3 4KB above");
      probe(32'h1234_4FFF, 0, 4'h5, 0, "R3 4KB below");
      wr(0, 1, 32'h8000_0016, 0, "R3 2GB write");
      probe(32'hFFFF_FFFF, 0, 4'h5, 1, "R3 2GB top");
      probe(32'h7FFF_FFFF, 0, 4'h5, 0, "R3 2GB below");
   endtask

   task automatic t_reserved;
      logic [4:0] codes [4] = '{5'd1, 5'd2, 5'd23, 5'd31};
      foreach (codes[k]) begin
         wr(0, 1, {27'd0, codes[k]}, 0, "R5 write");
         rd(0, {27'd0, codes[k]}, "R5 readback");
         probe(32'h0000_0000, 0, 4'h9, 0, "R5 no hit");
      end
      wr(0, 1, 32'h0, 0, "R5 zero code");
      probe(32'h0000_0000, 0, 4'h9, 0, "R5 zero no hit");
   endtask

   task automatic t_user;
      wr(0, 0, 32'h5000_0003, 1, "R8 user write fault");
      rd(0, 32'h0, "R8 ns unchanged");
      probe(32'h5000_0000, 0, 4'h2, 0, "R8 no new region");
      @(negedge clk);
      cfg_en = 1; cfg_wr = 0; cfg_priv = 0; cfg_secure = 1;
      #1 check("R8 user read fault", {31'd0, undef_fault}, 32'd1);
      check("R8 user read zero", cfg_rdata, 32'h0);
      cfg_en = 0;
   endtask

   task automatic t_lock;
      sec_wr_lock = 1;
      wr(1, 1, 32'h2000_0003, 1, "R9 locked secure write");
      rd(1, 32'h8000_5007, "R9 secure unchanged");
      wr(0, 1, 32'h2000_0003, 0, "R9 ns write allowed");
      rd(0, 32'h2000_0003, "R9 ns applied");
      sec_wr_lock = 0;
   endtask

   task automatic t_timing;
      @(negedge clk);
      acc_addr = 32'h6000_0000; acc_secure = 1; in_attr = 4'h7;
      cfg_en = 1; cfg_wr = 1; cfg_priv = 1; cfg_secure = 1; cfg_wdata = 32'h6000_0003;
      #1 check("R10 old value in write cycle", {31'd0, to_periph}, 32'd0);
      @(negedge clk);
      cfg_en = 0; cfg_wr = 0;
      #1 check("R10 new value next cycle", {31'd0, to_periph}, 32'd1);
      check("R10 R6 forced attr", {28'd0, out_attr}, 32'd1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      t_reset();
      t_basic();
      t_mask();
      t_extremes();
      t_reserved();
      t_user();
      t_lock();
      t_timing();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule